// File: doc/BRIEF.md
# Ring Frame Node

This block is the per-module attachment point on a one-way ring that carries command frames from a central controller and result frames back to it. Bytes arrive one at a time from the upstream neighbour and leave one at a time toward the downstream neighbour. Each byte crosses between neighbours over a single-rail bundled-data link with a four-phase request/acknowledge handshake. The incoming request and the returning acknowledge each pass through a two-flop synchroniser in the receiving clock domain.

Every frame is six bytes long. The node decodes the leading byte. A frame that names this node has its command and two information words handed to the local module, and its trailing status byte is rewritten with this node's view of the command. An empty frame that passes by can be claimed, and is then overwritten with a result that the module has queued for the controller. Any other frame is forwarded untouched. The node holds one byte at a time, so the upstream handshake of byte k+1 never completes before byte k has been passed downstream.

Top module: `ring_node`

## Requirements
- R1: A frame is six bytes. Byte 0 carries the target address in bits 7:5 and the command code in bits 4:0. Bytes 1–2 carry the first information word, high byte first. Bytes 3–4 carry the second information word, high byte first. Byte 5 is the status byte. Address 0 is the controller. Address 7 with command 0 is an empty frame.
- R2: Both links use a four-phase handshake with two-flop synchronisers. `tx_data` stays stable while `tx_req` is high. `tx_req` is not raised again until `tx_ack` has been seen low. `rx_ack` is released only after `rx_req` has been seen low.
- R3: A frame whose address is neither this node's nor a claimed empty frame leaves byte-for-byte unchanged.
- R4: Latency is one byte. Byte k has been offered downstream before the upstream handshake of byte k+1 completes. All six bytes of a frame are emitted with no further input.
- R5: In a frame addressed to this node, bytes 0–4 pass unchanged. In the status byte, bits 7:4 are kept, bit 0 (received) is set to 1, bit 1 is busy, bit 2 is error, and bit 3 (executed) is set when neither busy nor error is set.
- R6: For an addressed frame that is neither busy nor in error, `cmd_valid` pulses for one cycle in the cycle after the status byte is accepted. `cmd_code`, `cmd_info1` and `cmd_info2` carry the frame's values during that cycle.
- R7: If `mod_busy` is high when the status byte of an addressed frame is accepted, the busy bit is set and no `cmd_valid` pulse is produced.
- R8: A command code of `NUM_CMDS` (16) or above sets the error bit and produces no `cmd_valid` pulse. The frame is still forwarded.
- R9: `res_load` with no result pending captures `res_code`, `res_info1` and `res_info2` and raises `res_pending`. While a result is pending, `res_load` is ignored and the held result is kept.
- R10: An empty frame that arrives while a result is pending leaves as address 0 with the held code, followed by the two held words (high byte first) and a status byte of 0x00. `res_pending` drops after its status byte. An empty frame with no result pending passes unchanged.
- R11: After reset, `rx_ack`, `tx_req`, `cmd_valid` and `res_pending` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_req | input | 1 | Request from the upstream neighbour (asynchronous) |
| rx_data | input | 8 | Byte from the upstream neighbour, bundled with rx_req |
| rx_ack | output | 1 | Acknowledge to the upstream neighbour |
| tx_req | output | 1 | Request to the downstream neighbour |
| tx_data | output | 8 | Byte to the downstream neighbour |
| tx_ack | input | 1 | Acknowledge from the downstream neighbour (asynchronous) |
| mod_busy | input | 1 | Local module is still executing an earlier command |
| cmd_valid | output | 1 | One-cycle pulse: a command is delivered |
| cmd_code | output | 5 | Delivered command code |
| cmd_info1 | output | 16 | Delivered first information word |
| cmd_info2 | output | 16 | Delivered second information word |
| res_load | input | 1 | Module offers a result |
| res_code | input | 5 | Result code |
| res_info1 | input | 16 | Result first word |
| res_info2 | input | 16 | Result second word |
| res_pending | output | 1 | A result is held, waiting for an empty frame |

## Verification
The status byte of a claimed empty frame clears the held result in the same cycle that a module can offer a new one. The bench provokes this by holding `res_load` high across a whole claimed frame, first with result A and then with result B. The claimed frame must carry A and never B, because B is ignored while A is pending. `res_pending` must be high again right after that frame, and the next empty frame must carry B. Random frames with random busy states and random result loads mix addressed, foreign, empty and bad-command traffic, and each case is judged against a bench model of the frame rewrite.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  localparam int ST_RCVD = 0;
  localparam int ST_BUSY = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_EXEC = 3;

  typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_REL} tx_state_e;
endpackage

// File: rtl/ring_sync.sv
module ring_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ring_hs_rx.sv
module ring_hs_rx #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_in,
  input  logic [BYTE_W-1:0] data_in,
  output logic              ack_out,
  input  logic              ready,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data
);
  logic req_s;

  ring_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .d(req_in), .q(req_s)
  );

  // data is bundled with req and held by the sender until ack is seen
  assign byte_valid = req_s && !ack_out && ready;
  assign byte_data  = data_in;

  always_ff @(posedge clk) begin
    if (rst)                    ack_out <= 1'b0;
    else if (byte_valid)        ack_out <= 1'b1;
    else if (ack_out && !req_s) ack_out <= 1'b0;
  end

  assert_ack_release_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_out) |-> $past(!req_s));
endmodule

// File: rtl/ring_hs_tx.sv
module ring_hs_tx
  import ring_node_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              ready,
  output logic              req_out,
  output logic [BYTE_W-1:0] data_out,
  input  logic              ack_in
);
  tx_state_e state;
  logic      ack_s;

  ring_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_in), .q(ack_s)
  );

  assign ready = (state == TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      req_out  <= 1'b0;
      data_out <= '0;
    end else begin
      case (state)
        TX_IDLE: if (load) begin
          data_out <= load_data;
          req_out  <= 1'b1;
          state    <= TX_REQ;
        end
        TX_REQ: if (ack_s) begin
          req_out <= 1'b0;
          state   <= TX_REL;
        end
        default: if (!ack_s) state <= TX_IDLE;
      endcase
    end
  end

  assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (req_out && !ack_s) |=> $stable(data_out));
  assert_no_early_req_R2: assert property (@(posedge clk) disable iff (rst)
    (!req_out && ack_s) |=> !req_out);
endmodule

// File: rtl/ring_frame_proc.sv
module ring_frame_proc
  import ring_node_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CMD_W     = 5,
  parameter int INFO_W    = 16,
  parameter int NODE_ADDR = 3,
  parameter int NUM_CMDS  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [ADDR_W+CMD_W-1:0] in_byte,
  output logic [ADDR_W+CMD_W-1:0] out_byte,
  input  logic                    mod_busy,
  input  logic                    res_load,
  input  logic [CMD_W-1:0]        res_code_in,
  input  logic [INFO_W-1:0]       res_info1_in,
  input  logic [INFO_W-1:0]       res_info2_in,
  output logic                    res_pending,
  output logic                    cmd_valid,
  output logic [CMD_W-1:0]        cmd_code,
  output logic [INFO_W-1:0]       cmd_info1,
  output logic [INFO_W-1:0]       cmd_info2
);
  localparam int BYTE_W     = ADDR_W + CMD_W;
  localparam int INFO_BYTES = INFO_W / BYTE_W;
  localparam int FRAME_LEN  = 2 + 2 * INFO_BYTES;
  localparam int IDX_W      = $clog2(FRAME_LEN);
  localparam int SH_W       = 2 * INFO_W;
  localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(FRAME_LEN - 1);
  localparam logic [ADDR_W-1:0] MY_ADDR    = ADDR_W'(NODE_ADDR);
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = '0;
  localparam logic [ADDR_W-1:0] EMPTY_ADDR = '1;
  localparam logic [CMD_W:0]    CMD_LIMIT  = (CMD_W+1)'(NUM_CMDS);

  logic [IDX_W-1:0]  idx;
  logic              mine_q, claim_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [SH_W-1:0]   info_sh;
  logic [CMD_W-1:0]  res_code_q;
  logic [SH_W-1:0]   res_sh;

  logic [ADDR_W-1:0] in_addr;
  logic [CMD_W-1:0]  in_cmd;
  logic              claim_now, err_now;
  logic [BYTE_W-1:0] stat;

  assign in_addr   = in_byte[BYTE_W-1 -: ADDR_W];
  assign in_cmd    = in_byte[CMD_W-1:0];
  assign claim_now = (idx == '0) && (in_addr == EMPTY_ADDR) && (in_cmd == '0) && res_pending;
  assign err_now   = ({1'b0, cmd_q} >= CMD_LIMIT);

  always_comb begin
    stat          = in_byte;
    stat[ST_RCVD] = 1'b1;
    stat[ST_BUSY] = mod_busy;
    stat[ST_ERR]  = err_now;
    stat[ST_EXEC] = !mod_busy && !err_now;
  end

  always_comb begin
    if (idx == '0)
      out_byte = claim_now ? {CTRL_ADDR, res_code_q} : in_byte;
    else if (idx == LAST_IDX)
      out_byte = claim_q ? '0 : (mine_q ? stat : in_byte);
    else
      out_byte = claim_q ? res_sh[SH_W-1 -: BYTE_W] : in_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx         <= '0;
      mine_q      <= 1'b0;
      claim_q     <= 1'b0;
      cmd_q       <= '0;
      info_sh     <= '0;
      res_pending <= 1'b0;
      res_code_q  <= '0;
      res_sh      <= '0;
      cmd_valid   <= 1'b0;
      cmd_code    <= '0;
      cmd_info1   <= '0;
      cmd_info2   <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (res_load && !res_pending) begin
        res_pending <= 1'b1;
        res_code_q  <= res_code_in;
        res_sh      <= {res_info1_in, res_info2_in};
      end
      if (in_valid) begin
        idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
        if (idx == '0) begin
          mine_q  <= (in_addr == MY_ADDR);
          claim_q <= claim_now;
          cmd_q   <= in_cmd;
        end else if (idx != LAST_IDX) begin
          info_sh <= {info_sh[SH_W-BYTE_W-1:0], in_byte};
          if (claim_q) res_sh <= res_sh << BYTE_W;
        end else begin
          if (mine_q && !mod_busy && !err_now) begin
            cmd_valid <= 1'b1;
            cmd_code  <= cmd_q;
            cmd_info1 <= info_sh[SH_W-1 -: INFO_W];
            cmd_info2 <= info_sh[INFO_W-1:0];
          end
          if (claim_q) res_pending <= 1'b0;
          mine_q  <= 1'b0;
          claim_q <= 1'b0;
        end
      end
    end
  end

  assert_cmd_not_busy_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(!mod_busy));
  assert_cmd_known_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ({1'b0, cmd_code} < CMD_LIMIT));
  assert_cmd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  assert_pending_drop_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(res_pending) |-> $past(claim_q && in_valid && (idx == LAST_IDX)));
endmodule

// File: rtl/ring_node.sv
module ring_node #(
  parameter int ADDR_W      = 3,
  parameter int CMD_W       = 5,
  parameter int INFO_W      = 16,
  parameter int NODE_ADDR   = 3,
  parameter int NUM_CMDS    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int BYTE_W     = ADDR_W + CMD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_req,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ack,
  output logic              tx_req,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              tx_ack,
  input  logic              mod_busy,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_code,
  output logic [INFO_W-1:0] cmd_info1,
  output logic [INFO_W-1:0] cmd_info2,
  input  logic              res_load,
  input  logic [CMD_W-1:0]  res_code,
  input  logic [INFO_W-1:0] res_info1,
  input  logic [INFO_W-1:0] res_info2,
  output logic              res_pending
);
  logic              tx_ready, byte_valid;
  logic [BYTE_W-1:0] byte_in, byte_out;

  ring_hs_rx #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .req_in(rx_req), .data_in(rx_data), .ack_out(rx_ack),
    .ready(tx_ready), .byte_valid(byte_valid), .byte_data(byte_in)
  );

  ring_frame_proc #(
    .ADDR_W(ADDR_W), .CMD_W(CMD_W), .INFO_W(INFO_W),
    .NODE_ADDR(NODE_ADDR), .NUM_CMDS(NUM_CMDS)
  ) u_proc (
    .clk(clk), .rst(rst), .in_valid(byte_valid), .in_byte(byte_in), .out_byte(byte_out),
    .mod_busy(mod_busy), .res_load(res_load), .res_code_in(res_code),
    .res_info1_in(res_info1), .res_info2_in(res_info2), .res_pending(res_pending),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_info1(cmd_info1), .cmd_info2(cmd_info2)
  );

  ring_hs_tx #(.BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk(clk), .rst(rst), .load(byte_valid), .load_data(byte_out), .ready(tx_ready),
    .req_out(tx_req), .data_out(tx_data), .ack_in(tx_ack)
  );
endmodule

// File: tb/tb_ring_node.sv
module tb_ring_node;
  localparam int NODE = 3;
  localparam int NCMD = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_req = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ack;
  logic        tx_req;
  logic [7:0]  tx_data;
  logic        tx_ack = 1'b0;
  logic        mod_busy = 1'b0;
  logic        cmd_valid;
  logic [4:0]  cmd_code;
  logic [15:0] cmd_info1, cmd_info2;
  logic        res_load = 1'b0;
  logic [4:0]  res_code = '0;
  logic [15:0] res_info1 = '0, res_info2 = '0;
  logic        res_pending;

  ring_node dut (
    .clk(clk), .rst(rst), .rx_req(rx_req), .rx_data(rx_data), .rx_ack(rx_ack),
    .tx_req(tx_req), .tx_data(tx_data), .tx_ack(tx_ack), .mod_busy(mod_busy),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_info1(cmd_info1), .cmd_info2(cmd_info2),
    .res_load(res_load), .res_code(res_code), .res_info1(res_info1), .res_info2(res_info2),
    .res_pending(res_pending)
  );

  always #5 clk = ~clk;

  int nvec = 0, nerr = 0;
  logic [7:0] obuf [0:4095];
  int ocnt = 0;
  int ccnt = 0;
  logic [4:0]  c_code;
  logic [15:0] c_i1, c_i2;

  logic [7:0]  fin [0:5];
  logic [7:0]  fexp [0:5];
  logic        m_pend = 1'b0;
  logic [4:0]  m_code = '0;
  logic [15:0] m_i1 = '0, m_i2 = '0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // downstream neighbour: captures each byte and acknowledges
  initial forever begin
    @(negedge clk);
    if (tx_req && !tx_ack) begin
      obuf[ocnt] = tx_data;
      ocnt++;
      tx_ack = 1'b1;
    end else if (!tx_req && tx_ack) begin
      tx_ack = 1'b0;
    end
  end

  // module side: records delivered commands
  initial forever begin
    @(negedge clk);
    if (cmd_valid) begin
      ccnt++;
      c_code = cmd_code; c_i1 = cmd_info1; c_i2 = cmd_info2;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_data = b;
    rx_req  = 1'b1;
    while (!rx_ack) @(negedge clk);
    rx_req = 1'b0;
    while (rx_ack) @(negedge clk);
  endtask

  task automatic load_result(input logic [4:0] c, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    res_load = 1'b1; res_code = c; res_info1 = a; res_info2 = b;
    if (!m_pend) begin m_pend = 1'b1; m_code = c; m_i1 = a; m_i2 = b; end
    @(negedge clk);
    res_load = 1'b0;
  endtask

  task automatic set_frame(input logic [2:0] ad, input logic [4:0] cm,
                           input logic [15:0] a, input logic [15:0] b, input logic [7:0] st);
    fin[0] = {ad, cm}; fin[1] = a[15:8]; fin[2] = a[7:0];
    fin[3] = b[15:8];  fin[4] = b[7:0];  fin[5] = st;
  endtask

  // applies fin[] and judges the output frame and the command port against the model
  task automatic run_frame(input logic upd_model);
    int base, c0;
    logic mine, empty, claim, err, exec;
    mine  = (fin[0][7:5] == 3'(NODE));
    empty = (fin[0][7:5] == 3'd7) && (fin[0][4:0] == 5'd0);
    claim = empty && m_pend;
    err   = (fin[0][4:0] >= 5'(NCMD));
    exec  = mine && !mod_busy && !err;
    for (int k = 0; k < 6; k++) fexp[k] = fin[k];
    if (claim) begin
      fexp[0] = {3'd0, m_code}; fexp[1] = m_i1[15:8]; fexp[2] = m_i1[7:0];
      fexp[3] = m_i2[15:8];     fexp[4] = m_i2[7:0];  fexp[5] = 8'h00;
    end else if (mine) begin
      fexp[5][0] = 1'b1; fexp[5][1] = mod_busy; fexp[5][2] = err; fexp[5][3] = exec;
    end
    base = ocnt; c0 = ccnt;
    for (int k = 0; k < 6; k++) begin
      send_byte(fin[k]);
      check(ocnt == base + k + 1, "R4 byte forwarded before next accepted", ocnt - base, k + 1);
    end
    repeat (4) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      if (claim)     check(obuf[base+k] == fexp[k], "R10 claimed empty frame", obuf[base+k], fexp[k]);
      else if (mine) check(obuf[base+k] == fexp[k], "R5 addressed frame status", obuf[base+k], fexp[k]);
      else           check(obuf[base+k] == fexp[k], "R3 pass-through", obuf[base+k], fexp[k]);
    end
    if (exec) begin
      check(ccnt == c0 + 1, "R6 command pulse count", ccnt - c0, 1);
      check({c_code, c_i1, c_i2} == {fin[0][4:0], fin[1], fin[2], fin[3], fin[4]},
            "R6 command fields", {c_code, c_i1[10:0]}, {fin[0][4:0], fin[1][2:0], fin[2]});
    end else if (mine && mod_busy) begin
      check(ccnt == c0, "R7 no pulse while busy", ccnt - c0, 0);
    end else if (mine) begin
      check(ccnt == c0, "R8 no pulse on bad command", ccnt - c0, 0);
    end else begin
      check(ccnt == c0, "R3 no pulse for foreign frame", ccnt - c0, 0);
    end
    if (claim && upd_model) m_pend = 1'b0;
    check(res_pending == m_pend, "R10 pending after frame", res_pending, m_pend);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check({rx_ack, tx_req, cmd_valid, res_pending} == 4'b0, "R11 reset state",
          {rx_ack, tx_req, cmd_valid, res_pending}, 0);

    set_frame(3'd0, 5'd9, 16'hA1B2, 16'hC3D4, 8'h5A); run_frame(1'b1);       // R3 to controller
    set_frame(3'(NODE), 5'd5, 16'h1234, 16'hBEEF, 8'hF0); run_frame(1'b1);   // R1 R5 R6
    mod_busy = 1'b1;
    set_frame(3'(NODE), 5'd2, 16'h0F0F, 16'h7777, 8'h00); run_frame(1'b1);   // R7
    mod_busy = 1'b0;
    set_frame(3'(NODE), 5'd20, 16'h5555, 16'hAAAA, 8'h30); run_frame(1'b1);  // R8
    mod_busy = 1'b1;
    set_frame(3'(NODE), 5'd31, 16'h0001, 16'h0002, 8'h00); run_frame(1'b1);  // R7 R8 together
    mod_busy = 1'b0;
    set_frame(3'd7, 5'd0, 16'h1111, 16'h2222, 8'h44); run_frame(1'b1);       // R10 no pending

    load_result(5'd17, 16'hCAFE, 16'hF00D);
    check(res_pending == 1'b1, "R9 pending after load", res_pending, 1);
    load_result(5'd3, 16'h0BAD, 16'h0BAD);                                    // R9 ignored
    set_frame(3'd7, 5'd0, 16'h0, 16'h0, 8'hFF); run_frame(1'b1);             // R10 claim
    check(res_pending == 1'b0, "R10 pending cleared", res_pending, 0);

    // concurrency: result offered continuously across a claimed frame
    @(negedge clk);
    res_load = 1'b1; res_code = 5'd21; res_info1 = 16'h1357; res_info2 = 16'h2468;
    m_pend = 1'b1; m_code = 5'd21; m_i1 = 16'h1357; m_i2 = 16'h2468;
    @(negedge clk);
    res_code = 5'd22; res_info1 = 16'h9ABC; res_info2 = 16'hDEF0;
    set_frame(3'd7, 5'd0, 16'h0, 16'h0, 8'h00); run_frame(1'b0);
    @(negedge clk); res_load = 1'b0;
    m_code = 5'd22; m_i1 = 16'h9ABC; m_i2 = 16'hDEF0;
    check(res_pending == 1'b1, "R9 new result taken after claim", res_pending, 1);
    set_frame(3'd7, 5'd0, 16'h0, 16'h0, 8'h00); run_frame(1'b1);

    for (int n = 0; n < 160; n++) begin
      logic [2:0] ad;
      logic [4:0] cm;
      int sel;
      sel = $urandom % 5;
      ad  = (sel == 0) ? 3'(NODE) : (sel == 1) ? 3'd7 : 3'($urandom);
      cm  = (sel == 1 && ($urandom % 2 == 0)) ? 5'd0 : 5'($urandom);
      mod_busy = ($urandom % 4 == 0);
      if ($urandom % 3 == 0)
        load_result(5'($urandom), 16'($urandom), 16'($urandom));
      set_frame(ad, cm, 16'($urandom), 16'($urandom), 8'($urandom));
      run_frame(1'b1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule